// File: doc/BRIEF.md
# Instruction Stream Cache Trace Compressor

This block shrinks the trace of committed instruction addresses as it is produced. A detector watches the program counter of each retired instruction and cuts the sequence into streams. A stream is a run of instructions at consecutive word addresses. It is described by its first address and its length in instructions. Each finished descriptor goes into a small queue, so the core is never held up. A set-associative stream cache then looks the descriptor up. A hit produces a short cache index on the index output. A miss produces the reserved index 0 on the index output and the full descriptor on the miss output, and the descriptor is then written into the cache.

The detector has two states. DS_EMPTY holds after reset and moves to DS_OPEN on the first accepted PC. DS_OPEN then holds until the next reset. The cache controller has three states. ST_IDLE moves to ST_LOOKUP when the queue holds a descriptor, and pops that descriptor on the same edge. ST_LOOKUP always moves to ST_EMIT: this is where the tag compare, the refill and the LRU update happen. ST_EMIT returns to ST_IDLE once every output that this descriptor needs has completed its handshake.

Top module: `isc_trace_compressor`

## Requirements
- R1: A PC equal to the previous PC plus 4 extends the open stream. Any other PC closes the open stream and starts a new one of length 1 at that PC. The closed stream's (start, length) is queued on the same edge that accepts the breaking PC.
- R2: A stream is closed when it reaches 255 instructions. The next PC starts a new stream even if it is sequential, so lengths always fit in 8 bits.
- R3: After reset, no previous PC is known. The first PC always starts a new stream and produces no descriptor.
- R4: The set is (start[6:2] XOR length[4:0]) for the default 32 sets. On a hit, the index output carries set*NWAY + way and the miss output stays idle.
- R5: On a miss, the index output carries 0 and the miss output carries the descriptor's start address and length. The descriptor is then installed in its set.
- R6: Way 0 of set 0 is never filled, so index 0 appears only for misses.
- R7: A refill takes the lowest-numbered empty allowed way. If the set has no empty allowed way, the refill takes the least recently used allowed way. Every hit and every refill makes that way the most recently used.
- R8: The queue holds BUF_DEPTH descriptors. A descriptor that arrives while the queue is full is dropped, and buf_overflow rises and stays high until reset.
- R9: Each output holds its valid signal and its data unchanged until ready is seen. Each output transfers exactly once per descriptor, and the next lookup waits until both outputs have finished.
- R10: With the queue empty and the controller idle, both outputs become valid after the third rising edge, counting the edge that accepts the breaking PC.
- R11: Reset leaves both outputs invalid, buf_overflow low and the cache empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 1 | A committed instruction address is present |
| pc | input | 32 | Committed instruction address |
| idx_valid | output | 1 | Index record valid |
| idx_ready | input | 1 | Index record accepted |
| idx_data | output | log2(NSET*NWAY) | Cache index, or 0 for a miss |
| miss_valid | output | 1 | Miss record valid |
| miss_ready | input | 1 | Miss record accepted |
| miss_sa | output | 32 | Start address of the missed stream |
| miss_len | output | 8 | Length of the missed stream in instructions |
| buf_overflow | output | 1 | Sticky flag: a descriptor was dropped |

## Verification
A descriptor enters the queue on the edge that accepts the breaking PC. It is popped on the next edge and looked up on the edge after that, so both outputs are valid after the third edge. The bench checks the low level after the first and second edges and the high level after the third. All stimulus is applied one time unit after a rising edge, and outputs are read at that point. The records that complete a handshake are captured on the falling edge, which lies between the driving point and the next rising edge. The captured sequence is compared in order against a table of expected indices and miss records, so any lag or duplicate shows up as a mismatch whatever the exact latency.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] sa;
        logic [LEN_W-1:0]  len;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_EMIT   = 2'd2
    } ctl_state_t;

    typedef enum logic {
        DS_EMPTY = 1'b0,
        DS_OPEN  = 1'b1
    } det_state_t;
endpackage

// File: rtl/isc_stream_detect.sv
`timescale 1ns/1ps
module isc_stream_detect
    import isc_pkg::*;
#(
    parameter int MAX_LEN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc,
    output logic              desc_push,
    output desc_t             desc_out
);
    det_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ppc_q, sa_q;
    logic [LEN_W-1:0]  len_q;
    logic              seq_next, at_cap, brk;

    assign seq_next = (pc == ppc_q + ADDR_W'(4));
    assign at_cap   = (len_q == LEN_W'(MAX_LEN));
    assign brk      = !seq_next || at_cap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_EMPTY: if (pc_valid) state_d = DS_OPEN;
            DS_OPEN:  state_d = DS_OPEN;
            default:  state_d = DS_EMPTY;
        endcase
    end

    // stream tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ppc_q <= '0;
            sa_q  <= '0;
            len_q <= '0;
        end else if (pc_valid) begin
            ppc_q <= pc;
            unique case (state_q)
                DS_EMPTY: begin
                    sa_q  <= pc;
                    len_q <= LEN_W'(1);
                end
                DS_OPEN: begin
                    if (brk) begin
                        sa_q  <= pc;
                        len_q <= LEN_W'(1);
                    end else begin
                        len_q <= len_q + LEN_W'(1);
                    end
                end
                default: begin
                    sa_q  <= pc;
                    len_q <= LEN_W'(1);
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        desc_push    = 1'b0;
        desc_out.sa  = sa_q;
        desc_out.len = len_q;
        unique case (state_q)
            DS_OPEN:  desc_push = pc_valid && brk;
            DS_EMPTY: desc_push = 1'b0;
            default:  desc_push = 1'b0;
        endcase
    end

    p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_OPEN) |-> (len_q != '0) && (len_q <= LEN_W'(MAX_LEN)));

    p_new_stream_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_push |=> (len_q == LEN_W'(1)) && (sa_q == $past(pc)));
endmodule

// File: rtl/isc_desc_fifo.sv
`timescale 1ns/1ps
module isc_desc_fifo
    import isc_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  desc_t wdata,
    input  logic  pop,
    output desc_t rdata,
    output logic  empty,
    output logic  full,
    output logic  ovf
);
    desc_t          mem_q [DEPTH];
    logic [PW-1:0]  wp_q, rp_q;
    logic [CW-1:0]  cnt_q;
    logic           do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp_q <= wp_q + PW'(1);
            if (do_pop)  rp_q <= rp_q + PW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/isc_stream_cache.sv
`timescale 1ns/1ps
module isc_stream_cache
    import isc_pkg::*;
#(
    parameter  int NSET  = 32,
    parameter  int NWAY  = 4,
    localparam int SET_W = $clog2(NSET),
    localparam int WAY_W = $clog2(NWAY),
    localparam int IDX_W = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_avail,
    input  desc_t             desc_in,
    output logic              desc_pop,
    output logic              idx_valid,
    input  logic              idx_ready,
    output logic [IDX_W-1:0]  idx_data,
    output logic              miss_valid,
    input  logic              miss_ready,
    output logic [ADDR_W-1:0] miss_sa,
    output logic [LEN_W-1:0]  miss_len
);
    ctl_state_t        state_q, state_d;
    desc_t             cur_q;
    logic              hit_q;
    logic [IDX_W-1:0]  idx_q;
    logic              idx_done_q, miss_done_q;

    logic [NWAY-1:0]   vld_q    [NSET];
    logic [ADDR_W-1:0] tag_sa_q [NSET][NWAY];
    logic [LEN_W-1:0]  tag_sl_q [NSET][NWAY];
    logic [WAY_W-1:0]  age_q    [NSET][NWAY];

    logic [SET_W-1:0]  set_c;
    logic [NWAY-1:0]   hit_vec, alloc_ok;
    logic              hit_c, vf_found;
    logic [WAY_W-1:0]  hit_way, vict_way, touch_way, vf_age;
    logic              idx_fin, miss_fin;

    assign set_c = cur_q.sa[2 +: SET_W] ^ cur_q.len[SET_W-1:0];

    generate
        for (genvar w = 0; w < NWAY; w++) begin : g_way
            assign hit_vec[w]  = vld_q[set_c][w] &&
                                 (tag_sa_q[set_c][w] == cur_q.sa) &&
                                 (tag_sl_q[set_c][w] == cur_q.len);
            if (w == 0) begin : g_res
                assign alloc_ok[w] = (set_c != '0);
            end else begin : g_free
                assign alloc_ok[w] = 1'b1;
            end
        end
    endgenerate

    assign hit_c = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = NWAY - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // victim: first empty allowed way, else oldest allowed way
    always_comb begin
        vf_found = 1'b0;
        vf_age   = '0;
        vict_way = '0;
        for (int w = 0; w < NWAY; w++) begin
            if (!vf_found && alloc_ok[w] && !vld_q[set_c][w]) begin
                vf_found = 1'b1;
                vict_way = WAY_W'(w);
            end
        end
        if (!vf_found) begin
            for (int w = 0; w < NWAY; w++) begin
                if (alloc_ok[w] && (!vf_found || age_q[set_c][w] > vf_age)) begin
                    vf_found = 1'b1;
                    vf_age   = age_q[set_c][w];
                    vict_way = WAY_W'(w);
                end
            end
        end
    end

    assign touch_way = hit_c ? hit_way : vict_way;
    assign idx_fin   = idx_done_q || idx_ready;
    assign miss_fin  = hit_q || miss_done_q || miss_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (desc_avail) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_EMIT;
            ST_EMIT:   if (idx_fin && miss_fin) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        desc_pop   = 1'b0;
        idx_valid  = 1'b0;
        miss_valid = 1'b0;
        idx_data   = idx_q;
        miss_sa    = cur_q.sa;
        miss_len   = cur_q.len;
        unique case (state_q)
            ST_IDLE:   desc_pop = desc_avail;
            ST_LOOKUP: ;
            ST_EMIT: begin
                idx_valid  = !idx_done_q;
                miss_valid = !hit_q && !miss_done_q;
            end
            default: ;
        endcase
    end

    // controller datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            hit_q       <= 1'b0;
            idx_q       <= '0;
            idx_done_q  <= 1'b0;
            miss_done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (desc_avail) cur_q <= desc_in;
                ST_LOOKUP: begin
                    hit_q       <= hit_c;
                    idx_q       <= hit_c ? {set_c, hit_way} : '0;
                    idx_done_q  <= 1'b0;
                    miss_done_q <= 1'b0;
                end
                ST_EMIT: begin
                    if (idx_valid && idx_ready)   idx_done_q  <= 1'b1;
                    if (miss_valid && miss_ready) miss_done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // valid bits and recency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSET; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < NWAY; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (state_q == ST_LOOKUP) begin
            if (!hit_c) vld_q[set_c][vict_way] <= 1'b1;
            for (int w = 0; w < NWAY; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[set_c][w] <= '0;
                else if (age_q[set_c][w] < age_q[set_c][touch_way])
                    age_q[set_c][w] <= age_q[set_c][w] + WAY_W'(1);
            end
        end
    end

    // tags
    always_ff @(posedge clk) begin
        if (state_q == ST_LOOKUP && !hit_c) begin
            tag_sa_q[set_c][vict_way] <= cur_q.sa;
            tag_sl_q[set_c][vict_way] <= cur_q.len;
        end
    end

    p_hold_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && !idx_ready) |=> idx_valid && $stable(idx_data));

    p_hold_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_ready) |=> miss_valid && $stable(miss_sa) && $stable(miss_len));

    p_miss_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && miss_valid) |-> (idx_data == '0));

    p_hit_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && hit_q) |-> (idx_data != '0));

    p_no_pop_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |-> !desc_pop);

    always_ff @(posedge clk) begin
        if (rst_n) p_reserved_slot_r6: assert (!vld_q[0][0]);
    end
endmodule

// File: rtl/isc_trace_compressor.sv
`timescale 1ns/1ps
module isc_trace_compressor
    import isc_pkg::*;
#(
    parameter  int NSET      = 32,
    parameter  int NWAY      = 4,
    parameter  int BUF_DEPTH = 8,
    parameter  int MAX_LEN   = 255,
    localparam int IDX_W     = $clog2(NSET * NWAY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc,
    output logic              idx_valid,
    input  logic              idx_ready,
    output logic [IDX_W-1:0]  idx_data,
    output logic              miss_valid,
    input  logic              miss_ready,
    output logic [ADDR_W-1:0] miss_sa,
    output logic [LEN_W-1:0]  miss_len,
    output logic              buf_overflow
);
    logic  det_push, q_pop, q_empty, q_full;
    desc_t det_desc, q_desc;

    isc_stream_detect #(.MAX_LEN(MAX_LEN)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_valid  (pc_valid),
        .pc        (pc),
        .desc_push (det_push),
        .desc_out  (det_desc)
    );

    isc_desc_fifo #(.DEPTH(BUF_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (det_push),
        .wdata (det_desc),
        .pop   (q_pop),
        .rdata (q_desc),
        .empty (q_empty),
        .full  (q_full),
        .ovf   (buf_overflow)
    );

    isc_stream_cache #(.NSET(NSET), .NWAY(NWAY)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_avail (!q_empty),
        .desc_in    (q_desc),
        .desc_pop   (q_pop),
        .idx_valid  (idx_valid),
        .idx_ready  (idx_ready),
        .idx_data   (idx_data),
        .miss_valid (miss_valid),
        .miss_ready (miss_ready),
        .miss_sa    (miss_sa),
        .miss_len   (miss_len)
    );

    p_drop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (det_push && q_full) |=> buf_overflow);
endmodule

// File: tb/tb_isc_trace_compressor.sv
`timescale 1ns/1ps
module tb_isc_trace_compressor;
    localparam int IW = 7;
    localparam int NV = 16;

    typedef struct packed {
        logic [31:0]   sa;
        logic [7:0]    len;
        logic [IW-1:0] idx;
        logic          miss;
    } vec_t;

    // set = sa[6:2] ^ len[4:0]; idx = set*4 + way
    localparam vec_t VEC [NV] = '{
        '{32'h020001f4, 8'd9,  7'd0,  1'b1},  // set20 way0
        '{32'h00001000, 8'd3,  7'd0,  1'b1},  // A set3 way0
        '{32'h020001f4, 8'd9,  7'd80, 1'b0},
        '{32'h00001000, 8'd3,  7'd12, 1'b0},
        '{32'h00002000, 8'd32, 7'd0,  1'b1},  // set0 -> way1
        '{32'h00002000, 8'd32, 7'd1,  1'b0},
        '{32'h00002000, 8'd3,  7'd0,  1'b1},  // B way1
        '{32'h00003000, 8'd3,  7'd0,  1'b1},  // C way2
        '{32'h00004000, 8'd3,  7'd0,  1'b1},  // D way3
        '{32'h00001000, 8'd3,  7'd12, 1'b0},  // A hit
        '{32'h00005000, 8'd3,  7'd0,  1'b1},  // E evicts B (way1)
        '{32'h00002000, 8'd3,  7'd0,  1'b1},  // B evicts C (way2)
        '{32'h00001000, 8'd3,  7'd12, 1'b0},
        '{32'h00005000, 8'd3,  7'd13, 1'b0},
        '{32'h00002000, 8'd3,  7'd14, 1'b0},
        '{32'h00004000, 8'd3,  7'd15, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pc_valid = 1'b0;
    logic [31:0]   pc = '0;
    logic          idx_ready = 1'b1;
    logic          miss_ready = 1'b1;
    logic          idx_valid, miss_valid, buf_overflow;
    logic [IW-1:0] idx_data;
    logic [31:0]   miss_sa;
    logic [7:0]    miss_len;

    always #5 clk = ~clk;

    isc_trace_compressor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_valid     (pc_valid),
        .pc           (pc),
        .idx_valid    (idx_valid),
        .idx_ready    (idx_ready),
        .idx_data     (idx_data),
        .miss_valid   (miss_valid),
        .miss_ready   (miss_ready),
        .miss_sa      (miss_sa),
        .miss_len     (miss_len),
        .buf_overflow (buf_overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_idx = 0;
    int n_miss = 0;
    logic [IW-1:0] cap_idx [512];
    logic [31:0]   cap_sa  [512];
    logic [7:0]    cap_len [512];

    // handshake monitor, between driving point and next rising edge
    always @(negedge clk) begin
        if (idx_valid && idx_ready) begin
            if (n_idx < 512) cap_idx[n_idx] = idx_data;
            n_idx++;
        end
        if (miss_valid && miss_ready) begin
            if (n_miss < 512) begin
                cap_sa[n_miss]  = miss_sa;
                cap_len[n_miss] = miss_len;
            end
            n_miss++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        pc_valid = 1'b0;
        idx_ready  = 1'b1;
        miss_ready = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic send_stream(input logic [31:0] sa, input int len);
        for (int k = 0; k < len; k++) begin
            pc_valid = 1'b1;
            pc = sa + 32'(4 * k);
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

    initial begin
        int bi, bm, m;
        logic [IW-1:0] s_idx;
        logic [31:0]   s_sa;
        string tag;

        // reset state, R11
        do_reset();
        chk(idx_valid == 1'b0, "R11", 64'(idx_valid), 0);
        chk(miss_valid == 1'b0, "R11", 64'(miss_valid), 0);
        chk(buf_overflow == 1'b0, "R11", 64'(buf_overflow), 0);

        // latency, first-PC and handshake (R3, R10, R9)
        idx_ready = 1'b0;
        miss_ready = 1'b0;
        bi = n_idx; bm = n_miss;
        send_stream(32'h4, 2);
        pc_valid = 1'b1; pc = 32'h500;
        tick();                               // capture edge of breaking PC
        pc_valid = 1'b0;
        chk(idx_valid == 1'b0, "R10", 64'(idx_valid), 0);
        tick();
        chk(idx_valid == 1'b0, "R10", 64'(idx_valid), 0);
        tick();
        chk(idx_valid == 1'b1 && miss_valid == 1'b1, "R10", 64'({idx_valid, miss_valid}), 64'h3);
        chk(idx_data == '0, "R5", 64'(idx_data), 0);
        chk(miss_sa == 32'h4 && miss_len == 8'd2, "R3", {miss_sa, 24'h0, miss_len}, {32'h4, 32'h2});
        s_idx = idx_data; s_sa = miss_sa;
        tick(); tick();
        chk(idx_valid && miss_valid && idx_data == s_idx && miss_sa == s_sa, "R9",
            64'({idx_valid, miss_valid}), 64'h3);
        miss_ready = 1'b1;
        tick();
        chk(miss_valid == 1'b0 && idx_valid == 1'b1, "R9", 64'({idx_valid, miss_valid}), 64'h2);
        idx_ready = 1'b1;
        tick();
        chk(idx_valid == 1'b0, "R9", 64'(idx_valid), 0);
        repeat (5) tick();
        chk(n_idx - bi == 1, "R9", 64'(n_idx - bi), 1);
        chk(n_miss - bm == 1, "R3", 64'(n_miss - bm), 1);

        // table walk: mapping, hits, misses, reserved slot, LRU
        do_reset();
        bi = n_idx; bm = n_miss;
        for (int r = 0; r < NV; r++) send_stream(VEC[r].sa, int'(VEC[r].len));
        pc_valid = 1'b1; pc = 32'h00F00000;
        tick();
        pc_valid = 1'b0;
        repeat (80) tick();
        chk(n_idx - bi == NV, "R9", 64'(n_idx - bi), 64'(NV));
        m = 0;
        for (int r = 0; r < NV; r++) begin
            if (!VEC[r].miss) tag = (r == 5) ? "R6" : (r >= 12 ? "R7" : "R4");
            else tag = (r >= 10) ? "R7" : (r == 0 ? "R1" : "R5");
            chk(cap_idx[bi + r] == VEC[r].idx, tag, 64'(cap_idx[bi + r]), 64'(VEC[r].idx));
            if (VEC[r].miss) begin
                chk(cap_sa[bm + m] == VEC[r].sa && cap_len[bm + m] == VEC[r].len, tag,
                    {cap_sa[bm + m], 24'h0, cap_len[bm + m]}, {VEC[r].sa, 24'h0, VEC[r].len});
                m++;
            end
        end
        chk(n_miss - bm == m, "R4", 64'(n_miss - bm), 64'(m));

        // length cap, R2
        do_reset();
        bi = n_idx; bm = n_miss;
        send_stream(32'h00010000, 256);
        pc_valid = 1'b1; pc = 32'h900;
        tick();
        pc_valid = 1'b0;
        repeat (20) tick();
        chk(n_miss - bm == 2, "R2", 64'(n_miss - bm), 2);
        chk(cap_sa[bm] == 32'h00010000 && cap_len[bm] == 8'd255, "R2",
            {cap_sa[bm], 24'h0, cap_len[bm]}, {32'h00010000, 32'd255});
        chk(cap_sa[bm + 1] == 32'h000103FC && cap_len[bm + 1] == 8'd1, "R2",
            {cap_sa[bm + 1], 24'h0, cap_len[bm + 1]}, {32'h000103FC, 32'd1});

        // overflow, R8
        do_reset();
        chk(buf_overflow == 1'b0, "R11", 64'(buf_overflow), 0);
        bi = n_idx; bm = n_miss;
        for (int i = 0; i < 30; i++) begin
            pc_valid = 1'b1;
            pc = 32'h00040000 + 32'(i * 256);
            tick();
        end
        pc_valid = 1'b0;
        chk(buf_overflow == 1'b1, "R8", 64'(buf_overflow), 1);
        repeat (100) tick();
        chk(buf_overflow == 1'b1, "R8", 64'(buf_overflow), 1);
        chk(n_miss - bm < 29 && n_miss - bm >= 8, "R8", 64'(n_miss - bm), 64'd28);
        chk(cap_sa[bm] == 32'h00040000 && cap_len[bm] == 8'd1, "R8",
            {cap_sa[bm], 24'h0, cap_len[bm]}, {32'h00040000, 32'd1});
        do_reset();
        chk(buf_overflow == 1'b0, "R8", 64'(buf_overflow), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule